// File: doc/BRIEF.md
# Edge-Preserving Iterative Image Smoother

This block holds a small square image in on-chip registers and smooths it in place over a programmed number of passes. In every pass each pixel is paired with each of its four orthogonal neighbours. For a pair whose values lie close together, the two pixels pool a quarter of each value and split the pool evenly back between them. For a pair whose values differ by more than a programmable threshold, no exchange takes place, and each pixel keeps its own quarter. Flat regions therefore blur toward a Gaussian-like result while strong steps survive. The image is smoothed and segmented in a single operation.

Pixels are written through a load port and the threshold through a register write. A start pulse that carries an iteration count launches the run. One pass completes in every busy cycle. When the last pass completes, a single-cycle done pulse marks the end. Results are read back through a registered read port while the block is idle. All pixels of one pass are computed from the image as it stood before that pass.

Top module: `smooth_array`

## Requirements
- R1: After reset every pixel reads 0, the threshold is 0, `busy` is low and `done` is low.
- R2: With `busy` low, `ld_en` writes `ld_data` into pixel `ld_addr`, where pixel index = row*N + column. `rd_data` shows the pixel addressed by `rd_addr` at the previous clock edge.
- R3: Each pass replaces every pixel `p` with `(S + 4) >> 3`. Here S is the sum over its four edges of `p + q` when the edge is open, with `q` the neighbour's value, or `2*p` when the edge is closed. The sum is kept at three fractional bits and is rounded once.
- R4: An edge between two pixels is open exactly when the absolute difference of their values is less than or equal to the threshold. A difference equal to the threshold still exchanges.
- R5: An edge that leaves the image, at a border row or column, always counts as closed.
- R6: All pixels of a pass use the values from before that pass, including for the threshold comparison.
- R7: A `go` pulse with count K > 0 while idle raises `busy` at the next edge. `busy` then stays high for exactly K cycles, and K passes are applied. `done` is high for one cycle, starting at the same edge where `busy` falls.
- R8: A `go` with count 0 while idle applies no pass, leaves `busy` low, and pulses `done` in the next cycle.
- R9: While `busy` is high, `go`, `ld_en` and `thr_wr` are ignored. The running count, the image and the threshold in use are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Pixel write strobe |
| ld_addr | input | ADDR_W | Pixel write index (row*N + column) |
| ld_data | input | PIX_W | Pixel write value |
| thr_wr | input | 1 | Threshold register write strobe |
| thr_data | input | PIX_W | New threshold value |
| go | input | 1 | Start a run |
| go_iters | input | ITER_W | Number of passes for the run |
| rd_addr | input | ADDR_W | Pixel read index |
| rd_data | output | PIX_W | Registered read data |
| busy | output | 1 | Passes in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The smoothing is tried on a 4x4 array with five image patterns. A pseudo-random image has mixed differences, so it separates open edges from closed ones across many pairs. A vertical step shows that a large step survives while each flat side stays put. A fine checkerboard that differs by exactly 10 tells apart the two sides of the threshold comparison. A uniform image must pass through unchanged, which exposes any rounding bias, and a ramp exercises every border and corner. Each pattern is run under several thresholds and pass counts against an arithmetic model. Targeted runs then pin down exact corner and edge values, a zero-length run, and pokes at the inputs during a run.

// File: rtl/smooth_pkg.sv
package smooth_pkg;
  // Number of neighbour edges per pixel and fixed-point scaling of the pass sum.
  localparam int EDGES     = 4;
  localparam int FRAC_BITS = 3;

  typedef enum logic [1:0] {
    DIR_UP    = 2'd0,
    DIR_DOWN  = 2'd1,
    DIR_LEFT  = 2'd2,
    DIR_RIGHT = 2'd3
  } dir_e;

  typedef enum logic {
    CT_IDLE = 1'b0,
    CT_RUN  = 1'b1
  } ctrl_state_e;
endpackage

// File: rtl/smooth_edge.sv
module smooth_edge #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0] own,
  input  logic [PIX_W-1:0] nb,
  input  logic             present,
  input  logic [PIX_W-1:0] thr,
  output logic             open,
  output logic [PIX_W:0]   term
);
  logic [PIX_W-1:0] diff;

  always_comb begin
    diff = (own > nb) ? (own - nb) : (nb - own);
    open = present && (diff <= thr);
    // term is in units of 1/8: (own+nb)/8 when shared, own/4 = 2*own/8 when kept
    term = open ? ({1'b0, own} + {1'b0, nb}) : {own, 1'b0};
  end
endmodule

// File: rtl/smooth_pe.sv
module smooth_pe #(
  parameter int PIX_W = 8
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [PIX_W-1:0]                       own,
  input  logic [smooth_pkg::EDGES-1:0][PIX_W-1:0] nb,
  input  logic [smooth_pkg::EDGES-1:0]           present,
  input  logic [PIX_W-1:0]                       thr,
  output logic [PIX_W-1:0]                       nxt
);
  import smooth_pkg::*;

  localparam int ACC_W = PIX_W + FRAC_BITS;
  localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (FRAC_BITS - 1);

  logic [EDGES-1:0]            open_v;
  logic [EDGES-1:0][PIX_W:0]   term_v;
  logic [ACC_W-1:0]            acc;
  logic [ACC_W-1:0]            rnd;

  for (genvar d = 0; d < EDGES; d++) begin : g_edge
    smooth_edge #(.PIX_W(PIX_W)) u_edge (
      .own    (own),
      .nb     (nb[d]),
      .present(present[d]),
      .thr    (thr),
      .open   (open_v[d]),
      .term   (term_v[d])
    );
  end

  always_comb begin
    acc = '0;
    for (int d = 0; d < EDGES; d++) acc = acc + ACC_W'(term_v[d]);
    rnd = acc + HALF;
    nxt = rnd[ACC_W-1:FRAC_BITS];
  end

  // R4: a pixel with every edge closed keeps its value
  p_isolated_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (open_v == '0) |-> (nxt == own));
  // R5: an edge with no neighbour never opens
  p_border_closed_r5: assert property (@(posedge clk) disable iff (rst)
    ((open_v & ~present) == '0));
endmodule

// File: rtl/smooth_ctrl.sv
module smooth_ctrl #(
  parameter int ITER_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ITER_W-1:0] go_iters,
  output logic              busy,
  output logic              done
);
  import smooth_pkg::*;

  ctrl_state_e       state;
  logic [ITER_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= CT_IDLE;
      left  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        CT_IDLE: begin
          if (go) begin
            if (go_iters == '0) begin
              done <= 1'b1;
            end else begin
              state <= CT_RUN;
              left  <= go_iters;
            end
          end
        end
        default: begin
          left <= left - 1'b1;
          if (left == ITER_W'(1)) begin
            state <= CT_IDLE;
            done  <= 1'b1;
          end
        end
      endcase
    end
  end

  assign busy = (state == CT_RUN);

  // R7: the end of a run is always flagged
  p_fall_done_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  // R7: done never overlaps a run
  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R7: a run does not end before its count is used up
  p_run_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && left != ITER_W'(1)) |=> busy);
  // R8: zero-length run completes at once
  p_zero_run_r8: assert property (@(posedge clk) disable iff (rst)
    (go && !busy && go_iters == '0) |=> (done && !busy));
  // R9: go while running does not reload the count
  p_go_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && left != ITER_W'(1)) |=> (left == $past(left) - 1'b1));
endmodule

// File: rtl/smooth_array.sv
module smooth_array #(
  parameter  int N      = 16,
  parameter  int PIX_W  = 8,
  parameter  int ITER_W = 8,
  localparam int NPIX   = N * N,
  localparam int ADDR_W = (NPIX > 1) ? $clog2(NPIX) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [PIX_W-1:0]  ld_data,
  input  logic              thr_wr,
  input  logic [PIX_W-1:0]  thr_data,
  input  logic              go,
  input  logic [ITER_W-1:0] go_iters,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [PIX_W-1:0]  rd_data,
  output logic              busy,
  output logic              done
);
  import smooth_pkg::*;

  logic [NPIX-1:0][PIX_W-1:0] pix_q;
  logic [NPIX-1:0][PIX_W-1:0] pe_out;
  logic [PIX_W-1:0]           thr_q;

  smooth_ctrl #(.ITER_W(ITER_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .go      (go),
    .go_iters(go_iters),
    .busy    (busy),
    .done    (done)
  );

  // One processing element per pixel; absent neighbours are marked not present.
  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      localparam int IDX = r * N + c;
      logic [EDGES-1:0][PIX_W-1:0] nb_v;
      logic [EDGES-1:0]            pr_v;

      if (r > 0) begin : g_up
        assign nb_v[DIR_UP] = pix_q[IDX-N];
        assign pr_v[DIR_UP] = 1'b1;
      end else begin : g_up_edge
        assign nb_v[DIR_UP] = pix_q[IDX];
        assign pr_v[DIR_UP] = 1'b0;
      end

      if (r < N - 1) begin : g_dn
        assign nb_v[DIR_DOWN] = pix_q[IDX+N];
        assign pr_v[DIR_DOWN] = 1'b1;
      end else begin : g_dn_edge
        assign nb_v[DIR_DOWN] = pix_q[IDX];
        assign pr_v[DIR_DOWN] = 1'b0;
      end

      if (c > 0) begin : g_lf
        assign nb_v[DIR_LEFT] = pix_q[IDX-1];
        assign pr_v[DIR_LEFT] = 1'b1;
      end else begin : g_lf_edge
        assign nb_v[DIR_LEFT] = pix_q[IDX];
        assign pr_v[DIR_LEFT] = 1'b0;
      end

      if (c < N - 1) begin : g_rt
        assign nb_v[DIR_RIGHT] = pix_q[IDX+1];
        assign pr_v[DIR_RIGHT] = 1'b1;
      end else begin : g_rt_edge
        assign nb_v[DIR_RIGHT] = pix_q[IDX];
        assign pr_v[DIR_RIGHT] = 1'b0;
      end

      smooth_pe #(.PIX_W(PIX_W)) u_pe (
        .clk    (clk),
        .rst    (rst),
        .own    (pix_q[IDX]),
        .nb     (nb_v),
        .present(pr_v),
        .thr    (thr_q),
        .nxt    (pe_out[IDX])
      );
    end
  end

  // Image store: whole-image update on a pass, single-pixel write when idle.
  always_ff @(posedge clk) begin
    if (rst) begin
      pix_q <= '0;
    end else if (busy) begin
      pix_q <= pe_out;
    end else if (ld_en && (int'(ld_addr) < NPIX)) begin
      pix_q[ld_addr] <= ld_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q <= '0;
    end else if (thr_wr && !busy) begin
      thr_q <= thr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (int'(rd_addr) < NPIX) begin
      rd_data <= pix_q[rd_addr];
    end else begin
      rd_data <= '0;
    end
  end

  // R9: threshold is frozen during a run
  p_thr_hold_r9: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(thr_q));
  // R2: idle image changes only through the load port
  p_pix_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && !ld_en) |=> $stable(pix_q));
endmodule

// File: tb/tb_smooth_array.sv
module tb_smooth_array;
  localparam int N = 4;
  localparam int PIX_W = 8;
  localparam int ITER_W = 8;
  localparam int NPIX = N * N;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ld_en = 1'b0;
  logic [ADDR_W-1:0] ld_addr = '0;
  logic [PIX_W-1:0]  ld_data = '0;
  logic              thr_wr = 1'b0;
  logic [PIX_W-1:0]  thr_data = '0;
  logic              go = 1'b0;
  logic [ITER_W-1:0] go_iters = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [PIX_W-1:0]  rd_data;
  logic              busy;
  logic              done;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  int img [NPIX];
  int mdl [NPIX];

  always #10 clk = ~clk;

  smooth_array #(.N(N), .PIX_W(PIX_W), .ITER_W(ITER_W)) dut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .thr_wr(thr_wr), .thr_data(thr_data), .go(go), .go_iters(go_iters),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pattern(input int kind, input int i);
    int r = i / N;
    int c = i % N;
    case (kind)
      0: return (i * 73 + 41) % 256;
      1: return (c < 2) ? 30 : 200;
      2: return ((r + c) % 2 == 1) ? 100 : 110;
      3: return 77;
      default: return i * 16;
    endcase
  endfunction

  function automatic int edge_term(input int p, input int q, input bit pres, input int thr);
    int d = (p > q) ? p - q : q - p;
    if (pres && d <= thr) return p + q;
    return 2 * p;
  endfunction

  task automatic model_pass(input int thr);
    int old [NPIX];
    for (int i = 0; i < NPIX; i++) old[i] = mdl[i];
    for (int i = 0; i < NPIX; i++) begin
      int r = i / N;
      int c = i % N;
      int s = 0;
      s += edge_term(old[i], (r > 0)     ? old[i-N] : 0, r > 0,     thr);
      s += edge_term(old[i], (r < N - 1) ? old[i+N] : 0, r < N - 1, thr);
      s += edge_term(old[i], (c > 0)     ? old[i-1] : 0, c > 0,     thr);
      s += edge_term(old[i], (c < N - 1) ? old[i+1] : 0, c < N - 1, thr);
      mdl[i] = (s + 4) / 8;
    end
  endtask

  task automatic load_img();
    for (int i = 0; i < NPIX; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = ADDR_W'(i); ld_data = PIX_W'(img[i]);
      mdl[i] = img[i];
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic set_thr(input int t);
    @(negedge clk);
    thr_wr = 1'b1; thr_data = PIX_W'(t);
    @(negedge clk);
    thr_wr = 1'b0;
  endtask

  task automatic read_pix(input int a, output int v);
    @(negedge clk);
    rd_addr = ADDR_W'(a);
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic compare_all(input string req);
    int v;
    for (int i = 0; i < NPIX; i++) begin
      read_pix(i, v);
      check(v == mdl[i], req, v, mdl[i]);
    end
  endtask

  task automatic run(input int k, input bit poke);
    int cnt = 0;
    @(negedge clk);
    go = 1'b1; go_iters = ITER_W'(k);
    @(negedge clk);
    go = 1'b0;
    while (busy && cnt < 1000) begin
      cnt++;
      if (poke && cnt == 1) begin
        go = 1'b1; go_iters = 8'd7;
        ld_en = 1'b1; ld_addr = 4'd5; ld_data = 8'hEE;
        thr_wr = 1'b1; thr_data = 8'd0;
      end else begin
        go = 1'b0; ld_en = 1'b0; thr_wr = 1'b0;
      end
      @(negedge clk);
    end
    go = 1'b0; ld_en = 1'b0; thr_wr = 1'b0;
    check(cnt == k, "R7 busy length", cnt, k);
    check(done == 1'b1, "R7 done at busy fall", int'(done), 1);
    @(negedge clk);
    check(done == 1'b0, "R7 done single cycle", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v;
    int thrs [5] = '{0, 9, 10, 60, 255};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(done == 1'b0, "R1 done", int'(done), 0);
    for (int i = 0; i < NPIX; i++) mdl[i] = 0;
    compare_all("R1 pixel after reset");

    // R2: load and read back
    for (int i = 0; i < NPIX; i++) img[i] = pattern(0, i);
    load_img();
    compare_all("R2 readback");

    // R1: reset threshold is 0 -> a checkerboard of 10-step differences does not move
    for (int i = 0; i < NPIX; i++) img[i] = pattern(2, i);
    load_img();
    run(1, 1'b0);
    model_pass(0);
    compare_all("R1 reset threshold zero");

    // R3 R4 R6: sweep patterns, thresholds and pass counts
    for (int kind = 0; kind < 5; kind++) begin
      for (int ti = 0; ti < 5; ti++) begin
        for (int k = 1; k <= 3; k += 2) begin
          for (int i = 0; i < NPIX; i++) img[i] = pattern(kind, i);
          load_img();
          set_thr(thrs[ti]);
          run(k, 1'b0);
          for (int p = 0; p < k; p++) model_pass(thrs[ti]);
          compare_all("R3 R6 pass result");
        end
      end
    end

    // R4: threshold boundary on the checkerboard (difference exactly 10)
    for (int i = 0; i < NPIX; i++) img[i] = pattern(2, i);
    load_img();
    set_thr(10);
    run(1, 1'b0);
    read_pix(0, v);
    check(v == 108, "R4 equal difference opens", v, 108);
    load_img();
    set_thr(9);
    run(1, 1'b0);
    read_pix(0, v);
    check(v == 110, "R4 larger difference closes", v, 110);

    // R5: corner and border exact values
    for (int i = 0; i < NPIX; i++) img[i] = 0;
    img[0] = 80;
    load_img();
    set_thr(255);
    run(1, 1'b0);
    read_pix(0, v);
    check(v == 60, "R5 corner keeps border shares", v, 60);
    read_pix(1, v);
    check(v == 10, "R5 border neighbour", v, 10);
    read_pix(5, v);
    check(v == 0, "R5 R6 diagonal untouched", v, 0);

    // R8: zero-length run
    for (int i = 0; i < NPIX; i++) img[i] = pattern(4, i);
    load_img();
    @(negedge clk);
    go = 1'b1; go_iters = '0;
    @(negedge clk);
    go = 1'b0;
    check(busy == 1'b0, "R8 busy stays low", int'(busy), 0);
    check(done == 1'b1, "R8 done next cycle", int'(done), 1);
    @(negedge clk);
    check(done == 1'b0, "R8 done single cycle", int'(done), 0);
    compare_all("R8 image unchanged");

    // R9: go, load and threshold write during a run are ignored
    for (int i = 0; i < NPIX; i++) img[i] = pattern(0, i);
    load_img();
    set_thr(60);
    run(3, 1'b1);
    for (int p = 0; p < 3; p++) model_pass(60);
    compare_all("R9 pokes ignored");
    // threshold still 60 afterwards: one more pass must match a 60 pass
    run(1, 1'b0);
    model_pass(60);
    compare_all("R9 threshold kept");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule